// File: doc/BRIEF.md
# Unaligned Four-Word Instruction Fetch Array

This block is the data side of an instruction cache. In each cycle it returns four consecutive 32-bit instruction words from a 16-word cache block. The first word can sit at any word offset in the block, so no alignment is needed. A fetch names a set and a 4-bit start offset. One cycle later the four words come out in program order, and a per-slot valid mask shows which of them really belong to the block.

The block's words are spread over four banks. Word `w` sits in bank `w mod 4`, at row `w div 4` of that set. The set decode is the same for every bank. Each bank gets its own row within the block from a small row generator. If that bank's index is below `s mod 4`, the bank reads row `s div 4 + 1`. Otherwise it reads row `s div 4`. The four bank outputs then pass through a rotator, so slot 0 always holds the word at offset `s`. After the rotator they are registered.

A separate fill port writes a whole block in one cycle. Tag compare is done elsewhere and arrives as a hit input in the cycle the data is presented.

Top module: `ifa_fetch_array`

## Requirements
- R1: One cycle after a fetch with `rd_en`=1, set `q` and offset `s`, output slot `k` (bits `32k+31:32k` of `out_words`) holds word `s+k` of set `q`, for every slot whose mask bit is 1.
- R2: Every start offset from 0 to 15 is accepted, including offsets that are not multiples of four.
- R3: Mask bit `k` of `out_vld` is 0 whenever `s+k` > 15. Slot 0 is valid whenever `out_fire` is 1.
- R4: When `tag_hit` is 0, `out_fire` is 0 and `out_vld` is all zeros, whatever fetch is pending.
- R5: `out_fire` equals 1 only in the cycle after a cycle with `rd_en`=1, and only while `tag_hit` is 1.
- R6: A fill with `wr_en`=1 stores all 16 words of `wr_block` into set `wr_set` in one cycle. Word `w` occupies bits `32w+31:32w`. A fetch issued in the next cycle sees the new contents.
- R7: If a fill and a fetch target the same set in the same cycle, the fetch returns the contents from before the fill.
- R8: While reset is held, and until the first fetch after it, `out_fire`, `out_vld` and `out_words` are all zero.
- R9: A fill to one set leaves every other set unchanged.
- R10: A new fetch can be issued every cycle. Each result appears exactly one cycle after its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Fetch request strobe |
| rd_set | input | 6 | Set index of the fetch |
| rd_off | input | 4 | Start word offset within the block |
| tag_hit | input | 1 | Hit result from the tag side, for the fetch presented this cycle |
| wr_en | input | 1 | Block fill strobe |
| wr_set | input | 6 | Set index of the fill |
| wr_block | input | 512 | Sixteen fill words, word 0 in the low bits |
| out_words | output | 128 | Four fetched words, slot 0 in the low bits |
| out_vld | output | 4 | Per-slot valid mask |
| out_fire | output | 1 | Registered fetch strobe ANDed with `tag_hit` |

## Verification
A fetch result is due one clock edge after its request. `tag_hit` acts on it combinationally in that same output cycle. So, just after each falling edge, the bench first drives `tag_hit` for the pending result. It waits a short settle time and compares words, mask and fire against the expectation it recorded when the request was issued. Only after that does it drive the next request. That expectation comes from a bench-side copy of the storage, taken before the same cycle's fill is applied, which matches the read-old rule for a collision. Fill contents are visible from the request issued one cycle after the fill.

// File: rtl/ifa_pkg.sv
package ifa_pkg;

  // Row within the block that bank b must read so that, together, the banks
  // cover words s .. s+nb-1. Rows past the end wrap; those slots are masked.
  function automatic int row_for_bank(int s, int b, int nb, int rows);
    int base;
    base = s / nb;
    if (b < (s % nb)) base = base + 1;
    return base % rows;
  endfunction

  // Bank that feeds output slot k for start offset s.
  function automatic int src_bank(int s, int k, int nb);
    return (s + k) % nb;
  endfunction

  // Whether output slot k still lies inside the block.
  function automatic bit slot_inside(int s, int k, int words);
    return (s + k) < words;
  endfunction

endpackage

// File: rtl/ifa_row_gen.sv
module ifa_row_gen
  import ifa_pkg::*;
#(
  parameter int NB    = 4,
  parameter int ROWS  = 4,
  parameter int OFF_W = 4,
  parameter int ROW_W = 2
) (
  input  logic [OFF_W-1:0]            off,
  output logic [NB-1:0][ROW_W-1:0]    row
);

  for (genvar b = 0; b < NB; b++) begin : g_row
    always_comb begin
      row[b] = ROW_W'(row_for_bank(int'(off), b, NB, ROWS));
    end
  end

endmodule

// File: rtl/ifa_bank.sv
module ifa_bank #(
  parameter int SETS  = 64,
  parameter int ROWS  = 4,
  parameter int W     = 32,
  localparam int SET_W = $clog2(SETS),
  localparam int ROW_W = $clog2(ROWS),
  localparam int DEPTH = SETS * ROWS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SET_W-1:0]           rd_set,
  input  logic [ROW_W-1:0]           rd_row,
  output logic [W-1:0]               rd_data,
  input  logic                       wr_en,
  input  logic [SET_W-1:0]           wr_set,
  input  logic [ROWS-1:0][W-1:0]     wr_rows
);

  logic [W-1:0] mem [DEPTH];

  // The read is combinational, so a fill at the same edge is seen only by later reads.
  assign rd_data = mem[{rd_set, rd_row}];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int r = 0; r < ROWS; r++) begin
        mem[{wr_set, ROW_W'(r)}] <= wr_rows[r];
      end
    end
  end

  // R6: every row of this bank's part of the block holds the fill data after the edge.
  for (genvar r = 0; r < ROWS; r++) begin : g_chk
    p_fill_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem[{$past(wr_set), ROW_W'(r)}] == $past(wr_rows[r]));
  end

endmodule

// File: rtl/ifa_rotate.sv
module ifa_rotate
  import ifa_pkg::*;
#(
  parameter int NB    = 4,
  parameter int W     = 32,
  parameter int OFF_W = 4,
  localparam int BSEL_W = $clog2(NB)
) (
  input  logic [OFF_W-1:0]          off,
  input  logic [NB-1:0][W-1:0]      bank_data,
  output logic [NB-1:0][W-1:0]      slot_data
);

  for (genvar k = 0; k < NB; k++) begin : g_slot
    logic [BSEL_W-1:0] sel;
    always_comb begin
      sel          = BSEL_W'(src_bank(int'(off), k, NB));
      slot_data[k] = bank_data[sel];
    end
  end

endmodule

// File: rtl/ifa_slot_mask.sv
module ifa_slot_mask
  import ifa_pkg::*;
#(
  parameter int NB    = 4,
  parameter int WORDS = 16,
  parameter int OFF_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFF_W-1:0]  off,
  input  logic              fire,
  output logic [NB-1:0]     mask
);

  for (genvar k = 0; k < NB; k++) begin : g_m
    always_comb mask[k] = fire && slot_inside(int'(off), k, WORDS);
  end

  // R3: the valid slots always form a prefix of the window.
  p_mask_prefix_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask & (mask + NB'(1))) == '0);
  // R3: a presented fetch always has at least its first slot.
  p_slot0_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> mask[0]);
  // R4: no slot is valid without a presented fetch.
  p_mask_needs_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask != '0) |-> fire);

endmodule

// File: rtl/ifa_fetch_array.sv
module ifa_fetch_array #(
  parameter int SETS  = 64,
  parameter int W     = 32,
  parameter int NB    = 4,
  parameter int WORDS = 16,
  localparam int ROWS  = WORDS / NB,
  localparam int SET_W = $clog2(SETS),
  localparam int OFF_W = $clog2(WORDS),
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic [SET_W-1:0]     rd_set,
  input  logic [OFF_W-1:0]     rd_off,
  input  logic                 tag_hit,
  input  logic                 wr_en,
  input  logic [SET_W-1:0]     wr_set,
  input  logic [WORDS*W-1:0]   wr_block,
  output logic [NB*W-1:0]      out_words,
  output logic [NB-1:0]        out_vld,
  output logic                 out_fire
);

  logic [NB-1:0][ROW_W-1:0] bank_row;
  logic [NB-1:0][W-1:0]     bank_rd;
  logic [NB-1:0][W-1:0]     rot_words;
  logic [NB-1:0][W-1:0]     slot_q;
  logic [OFF_W-1:0]         off_q;
  logic                     req_q;

  ifa_row_gen #(.NB(NB), .ROWS(ROWS), .OFF_W(OFF_W), .ROW_W(ROW_W)) u_rows (
    .off (rd_off),
    .row (bank_row)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [ROWS-1:0][W-1:0] fill_rows;
    for (genvar r = 0; r < ROWS; r++) begin : g_fill
      assign fill_rows[r] = wr_block[(r*NB + b)*W +: W];
    end
    ifa_bank #(.SETS(SETS), .ROWS(ROWS), .W(W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_set  (rd_set),
      .rd_row  (bank_row[b]),
      .rd_data (bank_rd[b]),
      .wr_en   (wr_en),
      .wr_set  (wr_set),
      .wr_rows (fill_rows)
    );
  end

  ifa_rotate #(.NB(NB), .W(W), .OFF_W(OFF_W)) u_rot (
    .off       (rd_off),
    .bank_data (bank_rd),
    .slot_data (rot_words)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      off_q  <= '0;
      slot_q <= '0;
    end else begin
      req_q <= rd_en;
      if (rd_en) begin
        off_q  <= rd_off;
        slot_q <= rot_words;
      end
    end
  end

  assign out_fire  = req_q & tag_hit;
  assign out_words = slot_q;

  ifa_slot_mask #(.NB(NB), .WORDS(WORDS), .OFF_W(OFF_W)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .off   (off_q),
    .fire  (out_fire),
    .mask  (out_vld)
  );

  // R5: with no request in a cycle, nothing is presented in the next one.
  p_no_req_no_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !out_fire);
  // R10: the slot registers move only on a request.
  p_slots_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(out_words));

endmodule

// File: tb/sim_ifa_fetch_array.sv
`timescale 1ns/1ps
module sim_ifa_fetch_array;

  localparam int SETS = 64, W = 32, NB = 4, WORDS = 16;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               rd_en = 1'b0;
  logic [5:0]         rd_set = '0;
  logic [3:0]         rd_off = '0;
  logic               tag_hit = 1'b0;
  logic               wr_en = 1'b0;
  logic [5:0]         wr_set = '0;
  logic [WORDS*W-1:0] wr_block = '0;
  logic [NB*W-1:0]    out_words;
  logic [NB-1:0]      out_vld;
  logic               out_fire;

  ifa_fetch_array u0 (.*);

  always #2.5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  logic [W-1:0] model [SETS][WORDS];

  bit           p_rd = 1'b0;
  int           p_off = 0;
  logic [W-1:0] p_words [NB];
  string        p_tag = "R1";
  bit           done = 1'b0;

  task automatic expect_eq(input string req, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Check the pending result, then drive the next request and record its expectation.
  task automatic cycle(input bit hit, input bit rd, input int rset, input int roff,
                       input bit wr, input int wset, input string tag);
    bit ef;
    tag_hit = hit;
    #1;
    ef = p_rd && hit;
    expect_eq(hit ? "R5" : "R4", "out_fire", longint'(out_fire), longint'(ef));
    for (int k = 0; k < NB; k++) begin
      bit em;
      em = ef && (p_off + k <= WORDS - 1);
      expect_eq((p_off + k > WORDS - 1) ? "R3" : (hit ? p_tag : "R4"),
                $sformatf("out_vld[%0d]", k), longint'(out_vld[k]), longint'(em));
      if (em) expect_eq(p_tag, $sformatf("slot%0d off%0d", k, p_off),
                        longint'(out_words[k*W +: W]), longint'(p_words[k]));
    end
    rd_en  = rd;
    rd_set = 6'(rset);
    rd_off = 4'(roff);
    wr_en  = wr;
    wr_set = 6'(wset);
    if (wr) for (int w = 0; w < WORDS; w++) wr_block[w*W +: W] = $urandom;
    if (rd) begin
      p_off = roff;
      p_tag = tag;
      for (int k = 0; k < NB; k++) p_words[k] = model[rset][(roff + k) % WORDS];
    end
    p_rd = rd;
    if (wr) for (int w = 0; w < WORDS; w++) model[wset][w] = wr_block[w*W +: W];
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    tag_hit = 1'b1;
    #1;
    // R8: quiet outputs during reset
    expect_eq("R8", "fire in reset", longint'(out_fire), 0);
    expect_eq("R8", "vld in reset", longint'(out_vld), 0);
    expect_eq("R8", "words in reset", longint'(out_words[63:0]), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    expect_eq("R8", "fire after reset", longint'(out_fire), 0);
    expect_eq("R8", "words after reset", longint'(out_words[127:64]), 0);
    @(negedge clk);

    // R6: fill every set in one cycle each
    for (int s = 0; s < SETS; s++) cycle(1'b1, 1'b0, 0, 0, 1'b1, s, "R6");
    // R2/R10: every offset, back to back
    for (int o = 0; o < WORDS; o++) cycle(1'b1, 1'b1, 5, o, 1'b0, 0, "R2");
    // R4: pending fetch with a tag miss
    cycle(1'b1, 1'b1, 5, 13, 1'b0, 0, "R4");
    cycle(1'b0, 1'b0, 0, 0, 1'b0, 0, "R5");
    // R5: idle cycle
    cycle(1'b1, 1'b0, 0, 0, 1'b0, 0, "R5");
    // R7: fill and fetch on the same set in the same cycle
    cycle(1'b1, 1'b1, 9, 3, 1'b1, 9, "R7");
    cycle(1'b1, 1'b1, 9, 3, 1'b0, 0, "R6");
    // R9: fill set 7, then read neighbours
    cycle(1'b1, 1'b0, 0, 0, 1'b1, 7, "R9");
    cycle(1'b1, 1'b1, 6, 1, 1'b0, 0, "R9");
    cycle(1'b1, 1'b1, 8, 14, 1'b0, 0, "R9");
    cycle(1'b1, 1'b1, 7, 15, 1'b0, 0, "R6");

    // R1: random traffic
    for (int i = 0; i < 3000; i++) begin
      cycle(($urandom % 8) != 0, ($urandom % 4) != 0, $urandom % SETS, $urandom % WORDS,
            ($urandom % 5) == 0, $urandom % SETS, "R1");
    end
    cycle(1'b1, 1'b0, 0, 0, 1'b0, 0, "R1");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule